// File: doc/BRIEF.md
# Bulk-Erase Flash Command Interface

This block is a synthesizable behavioural model of the command side of a byte-wide flash memory with whole-chip erase. A small RAM array stands in for the cells. The host drives chip-enable, write-enable and output-enable strobes with an address and a data byte. The model samples every strobe on a fast internal clock, so writes and reads are cycles of that clock rather than asynchronous edges.

Commands are decoded by a small mode machine. The host can read the array, read two identifier bytes, program one byte, erase the whole chip, or return to read mode. Program and erase run on a self-timed engine whose durations are set by parameters in clock cycles. While the engine is busy, or after a failed program, any read returns a status byte instead of array data. That byte carries an inverted copy of the target bit 7, a bit 6 that flips on every new read, and a bit 5 that flags a time-out. A program-voltage-present input must be high for program or erase to start.

Top module: `flash_cmd_top`

## Requirements
- R1: After `rst_n` is released the block is in read-array mode and `dq_oe` is 0. If write-enable is low while reset is released, no write is accepted until write-enable has been seen high at least once.
- R2: A write cycle is the span in which `oe_n` is 1 and both `ce_n` and `we_n` are 0. Either `we_n` or `ce_n` may open and close the span. With `oe_n` at 0 nothing is written.
- R3: The address is taken in the first cycle of the write span. The data is the value present in the last cycle of the span. One command is issued per span.
- R4: Writing 10h or 50h, then a second write of address and data, starts a program. The stored byte becomes old AND new, so program never sets a bit.
- R5: Writing 30h twice starts a chip erase. The engine first writes 00h to every byte, waits ERASE_CYC cycles, then writes FFh to every byte. Afterwards every address reads FFh.
- R6: Status byte layout: bit 7 is the complement of bit 7 of the target data (FFh for erase), bit 6 is the toggle bit, bit 5 is the time-out flag, and bits 4..0 are 0. While an operation runs, bit 5 is 0. Once it completes, reads return true array data.
- R7: While an operation is running or has failed, bit 6 of the returned byte changes on each new read cycle. A new read cycle starts when `ce_n` and `oe_n` go low with `we_n` high.
- R8: If the program data has a 1 where the stored byte has a 0, verification never succeeds. After TIMEOUT_CYC cycles the stored byte is old AND new, status bit 5 reads 1, and this state holds until a reset command is written.
- R9: Writing 00h or FFh returns the block to read-array mode and clears a failed state. Writing FFh twice starting from program setup leaves the array contents unchanged and ends in read-array mode.
- R10: Writing 90h enters identifier mode. A read with address bit 0 clear returns MFR_ID (default 01h), and with bit 0 set returns DEV_ID (default A2h). Each code has odd parity.
- R11: If `vpp_ok` is 0 when the second cycle of a program or erase is written, no operation starts, the array is unchanged and the block returns to read-array mode.
- R12: Writes made while a program or erase is running are ignored.
- R13: A read returns its byte on `dq_o`, with `dq_oe` at 1, one clock after `ce_n` and `oe_n` are sampled low with `we_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_ok | input | 1 | Program voltage present |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data / command byte |
| dq_o | output | 8 | Read data or status byte |
| dq_oe | output | 1 | Output data valid / drive enable |

## Verification
The assertions take several things for granted about the inputs. The strobes are stable for whole clock cycles. `vpp_ok` does not change between a command write and the start of its operation. Program and erase are not started while a previous operation is still running. The stimulus changes every input only on the falling clock edge. It holds `vpp_ok` steady around each operation, and it polls the status byte until completion before it issues a new operation. The first operation after power-up is a chip erase, so the program-only-clears check never sees an unknown stored byte.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_RST_LO = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_RST_HI = 8'hFF;
  localparam logic [BYTE_W-1:0] CMD_IDENT  = 8'h90;
  localparam logic [BYTE_W-1:0] CMD_PRG_A  = 8'h10;
  localparam logic [BYTE_W-1:0] CMD_PRG_B  = 8'h50;
  localparam logic [BYTE_W-1:0] CMD_ERASE  = 8'h30;

  // status byte bit positions
  localparam int ST_POLL = 7;
  localparam int ST_TOG  = 6;
  localparam int ST_TOUT = 5;

  typedef enum logic [1:0] {
    MD_READ, MD_IDENT, MD_PSETUP, MD_ESETUP
  } mode_e;

  typedef enum logic [2:0] {
    EN_IDLE, EN_PROG, EN_PREZERO, EN_EWAIT, EN_EFILL, EN_FAIL
  } eng_e;

  function automatic logic is_reset_cmd(input logic [BYTE_W-1:0] d);
    return (d == CMD_RST_LO) || (d == CMD_RST_HI);
  endfunction
endpackage

// File: rtl/flash_bus_if.sv
module flash_bus_if
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] din,
  output logic              cmd_vld,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BYTE_W-1:0] cmd_data
);
  logic              armed_q, armed_d;
  logic              act, act_q;
  logic              vld_d, vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;
  logic              addr_en, data_en;

  always_comb begin
    armed_d = armed_q | we_n;
    act     = armed_q & ~ce_n & ~we_n & oe_n;
    addr_en = act & ~act_q;
    data_en = act;
    vld_d   = act_q & ~act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      act_q   <= 1'b0;
      vld_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      armed_q <= armed_d;
      act_q   <= act;
      vld_q   <= vld_d;
      if (addr_en) addr_q <= addr;
      if (data_en) data_q <= din;
    end
  end

  assign cmd_vld  = vld_q;
  assign cmd_addr = addr_q;
  assign cmd_data = data_q;

  // R3: a single write span yields exactly one command pulse
  assert_cmd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> !cmd_vld);
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              vpp_ok,
  input  logic              eng_busy,
  input  logic              eng_fail,
  output logic              mode_id,
  output logic              start_prog,
  output logic              start_erase,
  output logic              clr_fail,
  output logic [ADDR_W-1:0] op_addr,
  output logic [BYTE_W-1:0] op_data
);
  mode_e             md_q, md_d;
  logic              sp_d, se_d, cf_d;
  logic              sp_q, se_q, cf_q;
  logic [ADDR_W-1:0] oa_q;
  logic [BYTE_W-1:0] od_q;
  logic              take;

  always_comb begin
    md_d = md_q;
    sp_d = 1'b0;
    se_d = 1'b0;
    cf_d = 1'b0;
    take = cmd_vld & ~eng_busy;
    if (take) begin
      if (eng_fail) begin
        if (is_reset_cmd(cmd_data)) begin
          cf_d = 1'b1;
          md_d = MD_READ;
        end
      end else begin
        unique case (md_q)
          MD_READ, MD_IDENT: begin
            if (is_reset_cmd(cmd_data))                        md_d = MD_READ;
            else if (cmd_data == CMD_IDENT)                    md_d = MD_IDENT;
            else if (cmd_data == CMD_PRG_A || cmd_data == CMD_PRG_B) md_d = MD_PSETUP;
            else if (cmd_data == CMD_ERASE)                    md_d = MD_ESETUP;
          end
          MD_PSETUP: begin
            sp_d = vpp_ok;
            md_d = MD_READ;
          end
          MD_ESETUP: begin
            se_d = vpp_ok & (cmd_data == CMD_ERASE);
            md_d = MD_READ;
          end
          default: md_d = MD_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md_q <= MD_READ;
      sp_q <= 1'b0;
      se_q <= 1'b0;
      cf_q <= 1'b0;
      oa_q <= '0;
      od_q <= '0;
    end else begin
      md_q <= md_d;
      sp_q <= sp_d;
      se_q <= se_d;
      cf_q <= cf_d;
      if (sp_d) begin
        oa_q <= cmd_addr;
        od_q <= cmd_data;
      end
    end
  end

  assign mode_id     = (md_q == MD_IDENT);
  assign start_prog  = sp_q;
  assign start_erase = se_q;
  assign clr_fail    = cf_q;
  assign op_addr     = oa_q;
  assign op_data     = od_q;

  // R12: no operation is launched while the engine is still running
  assert_no_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_erase) |-> !eng_busy);
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int PROG_CYC    = 12,
  parameter int ERASE_CYC   = 16,
  parameter int TIMEOUT_CYC = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic              clr_fail,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [BYTE_W-1:0] op_data,
  input  logic [BYTE_W-1:0] cell_rdata,
  output logic [ADDR_W-1:0] cell_raddr,
  output logic              mem_we,
  output logic              mem_fill,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [BYTE_W-1:0] tgt_data,
  output logic              busy,
  output logic              fail
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int MAX_A   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_MAX = (TIMEOUT_CYC > MAX_A) ? TIMEOUT_CYC : MAX_A;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0]  PROG_LAST = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0]  ERS_LAST  = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0]  TO_LAST   = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [ADDR_W-1:0] WALK_END  = ADDR_W'(DEPTH - 1);

  eng_e              st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] walk_q, walk_d;
  logic [ADDR_W-1:0] pa_q;
  logic [BYTE_W-1:0] pd_q;
  logic              verify_ok;
  logic              walk_last;
  logic [BYTE_W-1:0] merged;

  always_comb begin
    merged    = cell_rdata & pd_q;
    verify_ok = (merged == pd_q);
    walk_last = (walk_q == WALK_END);
    st_d      = st_q;
    cnt_d     = cnt_q;
    walk_d    = walk_q;
    mem_we    = 1'b0;
    mem_fill  = 1'b0;
    mem_waddr = walk_q;
    mem_wdata = '0;
    unique case (st_q)
      EN_IDLE: begin
        if (start_prog) begin
          st_d  = EN_PROG;
          cnt_d = '0;
        end else if (start_erase) begin
          st_d   = EN_PREZERO;
          walk_d = '0;
        end
      end
      EN_PROG: begin
        mem_waddr = pa_q;
        mem_wdata = merged;
        cnt_d     = cnt_q + CNT_W'(1);
        if (cnt_q == PROG_LAST && verify_ok) begin
          mem_we = 1'b1;
          st_d   = EN_IDLE;
        end else if (cnt_q == TO_LAST) begin
          mem_we = 1'b1;
          st_d   = EN_FAIL;
        end
      end
      EN_PREZERO: begin
        mem_we = 1'b1;
        walk_d = walk_q + ADDR_W'(1);
        if (walk_last) begin
          st_d  = EN_EWAIT;
          cnt_d = '0;
        end
      end
      EN_EWAIT: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == ERS_LAST) begin
          st_d   = EN_EFILL;
          walk_d = '0;
        end
      end
      EN_EFILL: begin
        mem_we    = 1'b1;
        mem_fill  = 1'b1;
        mem_wdata = '1;
        walk_d    = walk_q + ADDR_W'(1);
        if (walk_last) st_d = EN_IDLE;
      end
      EN_FAIL: begin
        if (clr_fail) st_d = EN_IDLE;
      end
      default: st_d = EN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EN_IDLE;
      cnt_q  <= '0;
      walk_q <= '0;
      pa_q   <= '0;
      pd_q   <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      walk_q <= walk_d;
      if (st_q == EN_IDLE && start_prog) begin
        pa_q <= op_addr;
        pd_q <= op_data;
      end else if (st_q == EN_IDLE && start_erase) begin
        pd_q <= '1;
      end
    end
  end

  assign cell_raddr = pa_q;
  assign tgt_data   = pd_q;
  assign busy       = (st_q != EN_IDLE) && (st_q != EN_FAIL);
  assign fail       = (st_q == EN_FAIL);

  // R8: a failed program stays failed until a reset command clears it
  assert_fail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clr_fail) |=> fail);
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              fill,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [BYTE_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [BYTE_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];

  // R4: outside the erase fill phase a write may only clear bits
  assert_prog_clears_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !fill) |-> ((wdata & ~cells[waddr]) == '0));
endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
  import flash_cmd_pkg::*;
#(
  parameter int               ADDR_W      = 6,
  parameter int               PROG_CYC    = 12,
  parameter int               ERASE_CYC   = 16,
  parameter int               TIMEOUT_CYC = 30,
  parameter logic [BYTE_W-1:0] MFR_ID     = 8'h01,
  parameter logic [BYTE_W-1:0] DEV_ID     = 8'hA2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              vpp_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dq_o,
  output logic              dq_oe
);
  logic              cmd_vld;
  logic [ADDR_W-1:0] cmd_addr;
  logic [BYTE_W-1:0] cmd_data;
  logic              mode_id, start_prog, start_erase, clr_fail;
  logic [ADDR_W-1:0] op_addr;
  logic [BYTE_W-1:0] op_data;
  logic              eng_busy, eng_fail;
  logic [BYTE_W-1:0] tgt_data;
  logic              mem_we, mem_fill;
  logic [ADDR_W-1:0] mem_waddr, eng_raddr;
  logic [BYTE_W-1:0] mem_wdata, arr_rdata, eng_rdata;

  flash_bus_if #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din),
    .cmd_vld(cmd_vld), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  flash_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .vpp_ok(vpp_ok), .eng_busy(eng_busy),
    .eng_fail(eng_fail), .mode_id(mode_id), .start_prog(start_prog),
    .start_erase(start_erase), .clr_fail(clr_fail),
    .op_addr(op_addr), .op_data(op_data)
  );

  flash_op_engine #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog),
    .start_erase(start_erase), .clr_fail(clr_fail), .op_addr(op_addr),
    .op_data(op_data), .cell_rdata(eng_rdata), .cell_raddr(eng_raddr),
    .mem_we(mem_we), .mem_fill(mem_fill), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .tgt_data(tgt_data), .busy(eng_busy),
    .fail(eng_fail)
  );

  flash_cell_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .fill(mem_fill),
    .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(addr), .rdata_a(arr_rdata),
    .raddr_b(eng_raddr), .rdata_b(eng_rdata)
  );

  // read path
  logic              rd_act, rd_act_q, rd_start, op_act;
  logic              tog_q, tog_d;
  logic              id_rd_q, id_rd_d;
  logic [BYTE_W-1:0] status, rd_val;
  logic [BYTE_W-1:0] dq_q;
  logic              oe_q;

  always_comb begin
    rd_act   = ~ce_n & ~oe_n & we_n;
    rd_start = rd_act & ~rd_act_q;
    op_act   = eng_busy | eng_fail;
    tog_d    = (rd_start & op_act) ? ~tog_q : tog_q;
    status           = '0;
    status[ST_POLL]  = ~tgt_data[BYTE_W-1];
    status[ST_TOG]   = tog_d;
    status[ST_TOUT]  = eng_fail;
    if (op_act)       rd_val = status;
    else if (mode_id) rd_val = addr[0] ? DEV_ID : MFR_ID;
    else              rd_val = arr_rdata;
    id_rd_d = rd_act & ~op_act & mode_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      tog_q    <= 1'b0;
      id_rd_q  <= 1'b0;
      oe_q     <= 1'b0;
      dq_q     <= '0;
    end else begin
      rd_act_q <= rd_act;
      tog_q    <= tog_d;
      id_rd_q  <= id_rd_d;
      oe_q     <= rd_act;
      if (rd_act) dq_q <= rd_val;
    end
  end

  assign dq_o  = dq_q;
  assign dq_oe = oe_q;

  // R10: identifier bytes presented on the bus carry odd parity
  assert_id_parity_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && id_rd_q) |-> (^dq_o == 1'b1));

  // R11: an operation only begins when program voltage was present at its command
  assert_start_vpp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> $past(vpp_ok, 2));
endmodule

// File: tb/flash_cmd_top_tb.sv
module flash_cmd_top_tb;
  localparam int AW = 6;

  logic          clk;
  logic          rst_n;
  logic          ce_n, we_n, oe_n, vpp_ok;
  logic [AW-1:0] addr;
  logic [7:0]    din;
  logic [7:0]    dq_o;
  logic          dq_oe;

  flash_cmd_top #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .vpp_ok(vpp_ok), .addr(addr), .din(din), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    logic [7:0] msk;
    string      tag;
  } sb_item_t;
  sb_item_t sb_q[$];
  bit mon_req = 0;

  // monitor: pops one expectation per completed read
  always @(negedge clk) begin
    sb_item_t it;
    if (mon_req) begin
      it = sb_q.pop_front();
      n_chk++;
      if (!dq_oe || (((dq_o ^ it.exp) & it.msk) != 8'h00)) begin
        n_fail++;
        $display("FAIL %s: actual %02h (oe=%0b) expected %02h mask %02h",
                 it.tag, dq_o, dq_oe, it.exp, it.msk);
      end
      mon_req = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_ce(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; oe_n = 1'b1; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_exp(input logic [AW-1:0] a, input logic [7:0] e,
                        input logic [7:0] m, input string tag);
    sb_item_t it;
    it.exp = e; it.msk = m; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    @(posedge clk);
    #1 mon_req = 1;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd_get(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    v = dq_o;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic poll(input logic [AW-1:0] a, input int b, input logic val, input string tag);
    logic [7:0] v;
    bit hit = 0;
    for (int i = 0; i < 400 && !hit; i++) begin
      rd_get(a, v);
      if (v[b] == val) hit = 1;
    end
    check(hit, tag, v, val);
  endtask

  initial begin
    logic [7:0] v1, v2;
    rst_n = 1'b0; vpp_ok = 1'b1; addr = '0; din = '0;
    idle_bus();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(dq_oe == 1'b0, "R1 output disabled after reset", dq_oe, 0);

    // chip erase, status while busy
    wr(0, 8'h30);
    wr(0, 8'h30);
    rd_exp(3, 8'h00, 8'hBF, "R6 erase status: poll bit 0, timeout 0");
    rd_get(3, v1);
    rd_get(3, v2);
    check(v1[6] != v2[6], "R7 toggle bit flips between reads", v2[6], ~v1[6]);
    wr(0, 8'h90);  // R12: written while erase runs, must be ignored
    poll(3, 7, 1'b1, "R5 erase completes");
    rd_exp(0, 8'hFF, 8'hFF, "R5 erased byte at 0 / R12 ignored id cmd");
    rd_exp(AW'(63), 8'hFF, 8'hFF, "R5 erased last byte");
    rd_exp(5, 8'hFF, 8'hFF, "R5 erased byte at 5");

    // program A5 at 5
    wr(0, 8'h10);
    wr(5, 8'hA5);
    rd_exp(5, 8'h00, 8'hA0, "R6 program status poll bit is ~data7");
    poll(5, 7, 1'b1, "R4 program completes");
    rd_exp(5, 8'hA5, 8'hFF, "R4 programmed byte");

    // program 0F onto A5: needs bits set -> time-out
    wr(0, 8'h50);
    wr(5, 8'h0F);
    poll(5, 5, 1'b1, "R8 time-out flag rises");
    rd_exp(5, 8'hA0, 8'hBF, "R8 failed status holds");
    wr(0, 8'hFF);
    rd_exp(5, 8'h05, 8'hFF, "R8 failed byte is old AND new / R9 reset clears");

    // identifier mode
    wr(0, 8'h90);
    rd_exp(0, 8'h01, 8'hFF, "R10 manufacturer code");
    rd_exp(1, 8'hA2, 8'hFF, "R10 device code");
    rd_exp(AW'(3), 8'hA2, 8'hFF, "R10 address bit0 selects device code");
    wr(0, 8'h00);
    rd_exp(5, 8'h05, 8'hFF, "R9 reset 00h back to array read");

    // reset twice from program setup
    wr(0, 8'h10);
    wr(6, 8'hFF);
    poll(6, 7, 1'b1, "R9 first FF in setup completes");
    wr(0, 8'hFF);
    rd_exp(6, 8'hFF, 8'hFF, "R9 array unchanged at 6");
    rd_exp(5, 8'h05, 8'hFF, "R9 array unchanged at 5");

    // program voltage absent
    vpp_ok = 1'b0;
    wr(0, 8'h10);
    wr(7, 8'h00);
    rd_exp(7, 8'hFF, 8'hFF, "R11 program ignored without vpp");
    wr(0, 8'h30);
    wr(0, 8'h30);
    rd_exp(5, 8'h05, 8'hFF, "R11 erase ignored without vpp");
    vpp_ok = 1'b1;

    // write with output enable low is ignored
    @(negedge clk);
    addr = 0; din = 8'h90; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    idle_bus();
    repeat (3) @(negedge clk);
    rd_exp(0, 8'hFF, 8'hFF, "R2 write with oe_n low ignored");

    // chip-enable controlled program
    wr_ce(0, 8'h10);
    wr_ce(8, 8'h3C);
    poll(8, 7, 1'b0, "R2 ce-controlled program completes");
    rd_exp(8, 8'h3C, 8'hFF, "R2 ce-controlled program result");

    // address at span start, data at span end
    wr(0, 8'h10);
    @(negedge clk);
    addr = 9; din = 8'h11; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    addr = 10; din = 8'h81;
    @(negedge clk);
    idle_bus();
    repeat (3) @(negedge clk);
    poll(9, 7, 1'b1, "R3 program completes");
    rd_exp(9, 8'h81, 8'hFF, "R3 data from span end, address from span start");
    rd_exp(10, 8'hFF, 8'hFF, "R3 later address untouched");

    // reset returns to read mode; power-up write inhibit
    wr(0, 8'h90);
    @(negedge clk);
    rst_n = 1'b0;
    addr = 0; din = 8'h90; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_exp(0, 8'hFF, 8'hFF, "R1 read mode after reset, held-low strobe inhibited");

    // erase after programming clears everything
    wr(0, 8'h30);
    wr(0, 8'h30);
    poll(5, 7, 1'b1, "R5 second erase completes");
    rd_exp(5, 8'hFF, 8'hFF, "R5 re-erased 5");
    rd_exp(8, 8'hFF, 8'hFF, "R5 re-erased 8");
    rd_exp(9, 8'hFF, 8'hFF, "R5 re-erased 9");
    rd_exp(4, 8'hFF, 8'hFF, "R13 read data one clock after strobe");

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule